// File: doc/BRIEF.md
# Four-Wide Register Renamer

This block maps the architectural register numbers of a decoded group of up to four instructions onto physical register numbers, all in one cycle. A table holds the current physical register for each architectural register. A ring of unused physical register numbers hands out a new register for every instruction that writes a result. Inside the group, a source that an earlier slot writes takes that slot's new register instead of the table entry. When one architectural register is written more than once in the group, the last writer becomes the table's new mapping.

The renamed fields are combinational from the current inputs and state. The table and the ring change at the next rising clock edge, unless the group stalls. A group stalls as a whole when it needs more new registers than the ring holds. It then stays on the inputs and is offered again. For each writer the block also reports the register that the destination displaced. Later logic hands that register back through the release port once it is safe to reuse.

Top module: `rn_group_rename`

## Requirements
- R1: After reset, architectural register a maps to physical register a. The ring holds NUM_ARCH up to NUM_PHYS-1 in ascending order, so the first writers receive NUM_ARCH, NUM_ARCH+1 and so on.
- R2: Each slot with `in_valid` and `in_dst_en` both high gets the next unused ring entry, assigned in slot order 0 to 3. No two writers in a group get the same register.
- R3: A source that no earlier slot of the group writes reads the table's mapping as it stands before the group.
- R4: A source that an earlier slot of the same group writes reads the new register of the nearest such earlier slot. A slot's own destination never feeds its own sources.
- R5: When several slots of a group write one architectural register, the table keeps the new register of the highest-numbered such slot.
- R6: `stall` is high exactly when the number of writers exceeds the free count held before the edge. A stalled group renames nothing: `out_valid` is all zero, the table is unchanged and no ring entry is taken.
- R7: Slots with `in_valid` low, and valid slots without a destination, take no ring entry. `out_valid[j]` equals `in_valid[j]` whenever there is no stall.
- R8: A register presented on `rel_preg` with `rel_valid` high joins the tail of the ring at the edge, including in a stalled cycle. It is handed out after all registers already in the ring.
- R9: `out_pold` of a writer gives the register that its destination mapped to just before it: the nearest earlier writer in the group, or else the table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | GROUP_W | Slot holds an instruction |
| in_src_a | input | GROUP_W*AW | First source architectural register per slot |
| in_src_b | input | GROUP_W*AW | Second source architectural register per slot |
| in_dst_en | input | GROUP_W | Slot writes a destination |
| in_dst | input | GROUP_W*AW | Destination architectural register per slot |
| rel_valid | input | 1 | Return one register to the ring |
| rel_preg | input | PW | Register being returned |
| out_valid | output | GROUP_W | Slot renamed this cycle |
| out_psrc_a | output | GROUP_W*PW | Physical register for the first source |
| out_psrc_b | output | GROUP_W*PW | Physical register for the second source |
| out_pdst | output | GROUP_W*PW | New physical register for the destination (zero if none) |
| out_pold | output | GROUP_W*PW | Displaced physical register for the destination |
| stall | output | 1 | Group held for lack of free registers |

## Verification
The assertions assume that every register returned on the release port is one that the block reported as displaced and that has not been returned yet. Under that assumption the ring can never overflow and never holds a duplicate, so writers always get distinct registers. The bench keeps within this by holding its own queue of displaced registers, computed from its model, and by releasing only from the head of that queue. Source and destination numbers are drawn mostly from a small window so that same-group collisions and repeated writers occur often. Directed groups drain the ring to its edge, so that stalls and reuse of a returned register can be checked.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

   // where a renamed operand came from
   typedef enum logic {
      SRC_FROM_MAP   = 1'b0,
      SRC_FROM_GROUP = 1'b1
   } src_origin_e;

endpackage

// File: rtl/rnm_free_list.sv
module rnm_free_list #(
   parameter int unsigned NUM_ARCH = 32,
   parameter int unsigned NUM_PHYS = 64,
   parameter int unsigned LANES    = 4,
   parameter int unsigned PW       = $clog2(NUM_PHYS),
   parameter int unsigned NW       = $clog2(LANES + 1),
   parameter int unsigned CW       = $clog2(NUM_PHYS - NUM_ARCH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NW-1:0]       pop_n_i,
   input  logic                push_i,
   input  logic [PW-1:0]       push_preg_i,
   output logic [LANES*PW-1:0] peek_o,
   output logic [CW-1:0]       cnt_o
);

   localparam int unsigned DEPTH   = NUM_PHYS - NUM_ARCH;
   localparam int unsigned IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit          IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < LANES) begin : g_bad_depth
      $error("free ring shallower than group width");
   end

   logic [PW-1:0] mem_q [DEPTH];
   logic [IW-1:0] head_q, tail_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [IW-1:0] adv(input logic [IW-1:0] p, input int unsigned k);
      int unsigned s;
      s = int'(p) + k;
      if (s >= DEPTH) s = s - DEPTH;
      return IW'(s);
   endfunction

   // look-ahead of the next LANES entries; wrap style picked by depth
   for (genvar k = 0; k < LANES; k++) begin : g_peek
      logic [IW-1:0] idx;
      if (IS_POW2) begin : g_p2
         assign idx = head_q + IW'(k);
      end else begin : g_mod
         logic [IW:0] sum;
         assign sum = {1'b0, head_q} + (IW+1)'(k);
         assign idx = (sum >= (IW+1)'(DEPTH)) ? IW'(sum - (IW+1)'(DEPTH)) : sum[IW-1:0];
      end
      assign peek_o[k*PW +: PW] = mem_q[idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= PW'(NUM_ARCH + i);
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= CW'(DEPTH);
      end else begin
         if (push_i) begin
            mem_q[tail_q] <= push_preg_i;
            tail_q        <= adv(tail_q, 1);
         end
         head_q <= adv(head_q, int'(pop_n_i));
         cnt_q  <= cnt_q + CW'(push_i) - CW'(pop_n_i);
      end
   end

   assign cnt_o = cnt_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (cnt_q != CW'(DEPTH) || pop_n_i != '0)); // R8

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      32'(pop_n_i) <= 32'(cnt_q)); // R6

endmodule

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
   parameter int unsigned NUM_ARCH = 32,
   parameter int unsigned NUM_PHYS = 64,
   parameter int unsigned LANES    = 4,
   parameter int unsigned RD_PORTS = 12,
   parameter int unsigned AW       = $clog2(NUM_ARCH),
   parameter int unsigned PW       = $clog2(NUM_PHYS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [RD_PORTS*AW-1:0] rd_addr_i,
   output logic [RD_PORTS*PW-1:0] rd_data_o,
   input  logic [LANES-1:0]       we_i,
   input  logic [LANES*AW-1:0]    wa_i,
   input  logic [LANES*PW-1:0]    wd_i
);

   logic [PW-1:0] map_q [NUM_ARCH];

   for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
      assign rd_data_o[r*PW +: PW] = map_q[rd_addr_i[r*AW +: AW]];
   end

   // slots applied in order, so the highest writing slot lands last
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= PW'(a);
      end else begin
         for (int w = 0; w < LANES; w++) begin
            if (we_i[w]) map_q[wa_i[w*AW +: AW]] <= wd_i[w*PW +: PW];
         end
      end
   end

   logic [AW-1:0] top_wa;
   logic [PW-1:0] top_wd;
   assign top_wa = wa_i[(LANES-1)*AW +: AW];
   assign top_wd = wd_i[(LANES-1)*PW +: PW];

   AST_LAST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i[LANES-1] |=> map_q[$past(top_wa)] == $past(top_wd)); // R5

endmodule

// File: rtl/rnm_group_fwd.sv
module rnm_group_fwd
   import rnm_pkg::*;
#(
   parameter int unsigned LANES = 4,
   parameter int unsigned AW    = 5,
   parameter int unsigned PW    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LANES-1:0]    live_i,
   input  logic [LANES*AW-1:0] dst_i,
   input  logic [LANES*AW-1:0] src_a_i,
   input  logic [LANES*AW-1:0] src_b_i,
   input  logic [LANES*PW-1:0] tbl_a_i,
   input  logic [LANES*PW-1:0] tbl_b_i,
   input  logic [LANES*PW-1:0] tbl_old_i,
   input  logic [LANES*PW-1:0] new_i,
   output logic [LANES*PW-1:0] psrc_a_o,
   output logic [LANES*PW-1:0] psrc_b_o,
   output logic [LANES*PW-1:0] pold_o
);

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      src_origin_e   org_a, org_b, org_o;
      logic [PW-1:0] grp_a, grp_b, grp_o;

      // scan earlier slots upward so the nearest writer is kept
      always_comb begin
         org_a = SRC_FROM_MAP;
         org_b = SRC_FROM_MAP;
         org_o = SRC_FROM_MAP;
         grp_a = '0;
         grp_b = '0;
         grp_o = '0;
         for (int i = 0; i < j; i++) begin
            if (live_i[i]) begin
               if (dst_i[i*AW +: AW] == src_a_i[j*AW +: AW]) begin
                  org_a = SRC_FROM_GROUP;
                  grp_a = new_i[i*PW +: PW];
               end
               if (dst_i[i*AW +: AW] == src_b_i[j*AW +: AW]) begin
                  org_b = SRC_FROM_GROUP;
                  grp_b = new_i[i*PW +: PW];
               end
               if (dst_i[i*AW +: AW] == dst_i[j*AW +: AW]) begin
                  org_o = SRC_FROM_GROUP;
                  grp_o = new_i[i*PW +: PW];
               end
            end
         end
      end

      assign psrc_a_o[j*PW +: PW] = (org_a == SRC_FROM_GROUP) ? grp_a : tbl_a_i[j*PW +: PW];
      assign psrc_b_o[j*PW +: PW] = (org_b == SRC_FROM_GROUP) ? grp_b : tbl_b_i[j*PW +: PW];
      assign pold_o[j*PW +: PW]   = (org_o == SRC_FROM_GROUP) ? grp_o : tbl_old_i[j*PW +: PW];
   end

   if (LANES > 1) begin : g_adj_chk
      AST_FWD_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
         (live_i[0] && dst_i[0 +: AW] == src_a_i[AW +: AW]) |->
            psrc_a_o[PW +: PW] == new_i[0 +: PW]); // R4
   end

endmodule

// File: rtl/rn_group_rename.sv
module rn_group_rename
   import rnm_pkg::*;
#(
   parameter int unsigned NUM_ARCH = 32,
   parameter int unsigned NUM_PHYS = 64,
   parameter int unsigned GROUP_W  = 4,
   parameter int unsigned AW       = $clog2(NUM_ARCH),
   parameter int unsigned PW       = $clog2(NUM_PHYS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [GROUP_W-1:0]    in_valid,
   input  logic [GROUP_W*AW-1:0] in_src_a,
   input  logic [GROUP_W*AW-1:0] in_src_b,
   input  logic [GROUP_W-1:0]    in_dst_en,
   input  logic [GROUP_W*AW-1:0] in_dst,
   input  logic                  rel_valid,
   input  logic [PW-1:0]         rel_preg,
   output logic [GROUP_W-1:0]    out_valid,
   output logic [GROUP_W*PW-1:0] out_psrc_a,
   output logic [GROUP_W*PW-1:0] out_psrc_b,
   output logic [GROUP_W*PW-1:0] out_pdst,
   output logic [GROUP_W*PW-1:0] out_pold,
   output logic                  stall
);

   localparam int unsigned FL_DEPTH = NUM_PHYS - NUM_ARCH;
   localparam int unsigned NW       = $clog2(GROUP_W + 1);
   localparam int unsigned CW       = $clog2(FL_DEPTH + 1);
   localparam int unsigned RD_PORTS = 3 * GROUP_W;

   if (GROUP_W < 1) begin : g_bad_width
      $error("group width must be at least one");
   end
   if (NUM_PHYS < NUM_ARCH + GROUP_W) begin : g_bad_phys
      $error("too few physical registers for one full group");
   end
   if ((1 << AW) < NUM_ARCH || (1 << PW) < NUM_PHYS) begin : g_bad_idx
      $error("index width too narrow for register count");
   end

   logic [GROUP_W-1:0]    live;
   logic [NW-1:0]         need;
   logic [NW-1:0]         rank [GROUP_W];
   logic [GROUP_W*PW-1:0] fl_peek;
   logic [CW-1:0]         fl_cnt;
   logic [NW-1:0]         pop_n;
   logic [GROUP_W*PW-1:0] pdst_vec;
   logic [RD_PORTS*AW-1:0] rd_addr;
   logic [RD_PORTS*PW-1:0] rd_data;

   assign live = in_valid & in_dst_en;

   // running count of writers gives each writer its ring offset
   always_comb begin
      need = '0;
      for (int j = 0; j < GROUP_W; j++) begin
         rank[j] = need;
         need    = need + NW'(live[j]);
      end
   end

   assign stall = 32'(need) > 32'(fl_cnt);
   assign pop_n = stall ? '0 : need;

   for (genvar j = 0; j < GROUP_W; j++) begin : g_alloc
      logic [NW-1:0] lane;
      assign lane = (32'(rank[j]) < GROUP_W) ? rank[j] : '0;
      assign pdst_vec[j*PW +: PW] = live[j] ? fl_peek[lane*PW +: PW] : '0;
   end

   rnm_free_list #(
      .NUM_ARCH (NUM_ARCH),
      .NUM_PHYS (NUM_PHYS),
      .LANES    (GROUP_W),
      .PW       (PW),
      .NW       (NW),
      .CW       (CW)
   ) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .pop_n_i     (pop_n),
      .push_i      (rel_valid),
      .push_preg_i (rel_preg),
      .peek_o      (fl_peek),
      .cnt_o       (fl_cnt)
   );

   assign rd_addr = {in_dst, in_src_b, in_src_a};

   rnm_map_table #(
      .NUM_ARCH (NUM_ARCH),
      .NUM_PHYS (NUM_PHYS),
      .LANES    (GROUP_W),
      .RD_PORTS (RD_PORTS),
      .AW       (AW),
      .PW       (PW)
   ) u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data),
      .we_i      (live & {GROUP_W{~stall}}),
      .wa_i      (in_dst),
      .wd_i      (pdst_vec)
   );

   rnm_group_fwd #(
      .LANES (GROUP_W),
      .AW    (AW),
      .PW    (PW)
   ) u_fwd (
      .clk       (clk),
      .rst_n     (rst_n),
      .live_i    (live),
      .dst_i     (in_dst),
      .src_a_i   (in_src_a),
      .src_b_i   (in_src_b),
      .tbl_a_i   (rd_data[0 +: GROUP_W*PW]),
      .tbl_b_i   (rd_data[GROUP_W*PW +: GROUP_W*PW]),
      .tbl_old_i (rd_data[2*GROUP_W*PW +: GROUP_W*PW]),
      .new_i     (pdst_vec),
      .psrc_a_o  (out_psrc_a),
      .psrc_b_o  (out_psrc_b),
      .pold_o    (out_pold)
   );

   assign out_valid = in_valid & {GROUP_W{~stall}};
   assign out_pdst  = pdst_vec;

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> fl_cnt == $past(fl_cnt) + CW'($past(rel_valid))); // R6

   for (genvar i = 0; i < GROUP_W; i++) begin : g_dchk
      for (genvar k = i + 1; k < GROUP_W; k++) begin : g_pair
         AST_DST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[i] && in_dst_en[i] && out_valid[k] && in_dst_en[k]) |->
               out_pdst[i*PW +: PW] != out_pdst[k*PW +: PW]); // R2
      end
   end

endmodule

// File: tb/sim_rn_group_rename.sv
`timescale 1ns/1ps
module sim_rn_group_rename;

   localparam int NA  = 32;
   localparam int NP  = 64;
   localparam int W   = 4;
   localparam int AW  = 5;
   localparam int PW  = 6;
   localparam int FLD = NP - NA;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic              rst_n;
   logic [W-1:0]      in_valid, in_dst_en;
   logic [W*AW-1:0]   in_src_a, in_src_b, in_dst;
   logic              rel_valid;
   logic [PW-1:0]     rel_preg;
   logic [W-1:0]      out_valid;
   logic [W*PW-1:0]   out_psrc_a, out_psrc_b, out_pdst, out_pold;
   logic              stall;

   rn_group_rename u0 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .in_dst_en(in_dst_en), .in_dst(in_dst),
      .rel_valid(rel_valid), .rel_preg(rel_preg),
      .out_valid(out_valid), .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b),
      .out_pdst(out_pdst), .out_pold(out_pold), .stall(stall)
   );

   int m_map [NA];
   int fl_mem [FLD];
   int fl_head, fl_tail, fl_cnt;
   int pend [NP];
   int p_head, p_tail, p_cnt;
   int g_v [W], g_dv [W], g_a [W], g_b [W], g_d [W];
   int n_chk, n_err;

   task automatic chk(string req, string what, int slot, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s %s slot %0d: got %0d expected %0d", req, what, slot, got, exp);
      end
   endtask

   task automatic set_slot(int j, int v, int a, int b, int dv, int d);
      g_v[j] = v; g_a[j] = a; g_b[j] = b; g_dv[j] = dv; g_d[j] = d;
   endtask

   function automatic int rnd_reg();
      if ($urandom % 4 == 0) return int'($urandom % NA);
      return int'($urandom % 8);
   endfunction

   // one cycle: drive at negedge, check mid-cycle, update model at posedge
   task automatic step(string tag, bit do_rel);
      int  e_pd [W], e_a [W], e_b [W], e_old [W];
      bit  f_a [W];
      int  need;
      bit  stl;
      for (int j = 0; j < W; j++) begin
         in_valid[j]            = (g_v[j] != 0);
         in_dst_en[j]           = (g_dv[j] != 0);
         in_src_a[j*AW +: AW]   = AW'(g_a[j]);
         in_src_b[j*AW +: AW]   = AW'(g_b[j]);
         in_dst[j*AW +: AW]     = AW'(g_d[j]);
      end
      rel_valid = do_rel && (p_cnt > 0);
      rel_preg  = rel_valid ? PW'(pend[p_head]) : '0;

      need = 0;
      for (int j = 0; j < W; j++) begin
         if (g_v[j] != 0 && g_dv[j] != 0) begin
            e_pd[j] = fl_mem[(fl_head + need) % FLD];
            need++;
         end else e_pd[j] = 0;
      end
      stl = need > fl_cnt;
      for (int j = 0; j < W; j++) begin
         e_a[j] = m_map[g_a[j]]; e_b[j] = m_map[g_b[j]]; e_old[j] = m_map[g_d[j]];
         f_a[j] = 1'b0;
         for (int i = 0; i < j; i++) begin
            if (g_v[i] != 0 && g_dv[i] != 0) begin
               if (g_d[i] == g_a[j]) begin e_a[j] = e_pd[i]; f_a[j] = 1'b1; end
               if (g_d[i] == g_b[j]) e_b[j] = e_pd[i];
               if (g_d[i] == g_d[j]) e_old[j] = e_pd[i];
            end
         end
      end

      #1;
      chk(tag != "" ? tag : "R6", "stall", -1, int'(stall), int'(stl));
      for (int j = 0; j < W; j++) begin
         chk(tag != "" ? tag : "R7", "out_valid", j, int'(out_valid[j]),
             int'(g_v[j] != 0 && !stl));
         if (g_v[j] != 0 && !stl) begin
            chk(tag != "" ? tag : (f_a[j] ? "R4" : "R3"), "psrc_a", j,
                int'(out_psrc_a[j*PW +: PW]), e_a[j]);
            chk(tag != "" ? tag : "R3", "psrc_b", j, int'(out_psrc_b[j*PW +: PW]), e_b[j]);
            if (g_dv[j] != 0) begin
               chk(tag != "" ? tag : "R2", "pdst", j, int'(out_pdst[j*PW +: PW]), e_pd[j]);
               chk(tag != "" ? tag : "R9", "pold", j, int'(out_pold[j*PW +: PW]), e_old[j]);
            end
         end
      end

      @(posedge clk);
      if (rel_valid) begin
         fl_mem[fl_tail] = pend[p_head];
         fl_tail = (fl_tail + 1) % FLD;
         fl_cnt++;
         p_head = (p_head + 1) % NP;
         p_cnt--;
      end
      if (!stl) begin
         for (int j = 0; j < W; j++) begin
            if (g_v[j] != 0 && g_dv[j] != 0) begin
               m_map[g_d[j]] = e_pd[j];
               pend[p_tail] = e_old[j];
               p_tail = (p_tail + 1) % NP;
               p_cnt++;
            end
         end
         fl_head = (fl_head + need) % FLD;
         fl_cnt  = fl_cnt - need;
      end
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20251));
      n_chk = 0; n_err = 0;
      rst_n = 1'b0;
      in_valid = '0; in_dst_en = '0; in_src_a = '0; in_src_b = '0; in_dst = '0;
      rel_valid = 1'b0; rel_preg = '0;
      for (int a = 0; a < NA; a++) m_map[a] = a;
      for (int i = 0; i < FLD; i++) fl_mem[i] = NA + i;
      fl_head = 0; fl_tail = 0; fl_cnt = FLD;
      p_head = 0; p_tail = 0; p_cnt = 0;
      for (int j = 0; j < W; j++) set_slot(j, 0, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: idle, then first writers take the lowest non-architectural registers
      step("R1", 1'b0);
      set_slot(0, 1, 9, 10, 1, 1);
      set_slot(1, 1, 11, 12, 1, 2);
      set_slot(2, 1, 13, 14, 1, 3);
      set_slot(3, 1, 15, 16, 1, 4);
      step("R1", 1'b0);

      // R4: one register written three times in one group, nearest writer feeds
      set_slot(0, 1, 5, 5, 1, 5);
      set_slot(1, 1, 5, 6, 1, 5);
      set_slot(2, 1, 7, 5, 1, 5);
      set_slot(3, 1, 5, 5, 0, 0);
      step("R4", 1'b0);

      // R5: the table keeps the last writer; invalid slot with a destination ignored
      set_slot(0, 1, 5, 0, 1, 8);
      set_slot(1, 1, 8, 5, 1, 9);
      set_slot(2, 0, 1, 1, 1, 20);
      set_slot(3, 0, 2, 2, 0, 0);
      step("R5", 1'b0);

      // R2: drain the ring with full groups
      while (fl_cnt >= W) begin
         for (int j = 0; j < W; j++) set_slot(j, 1, rnd_reg(), rnd_reg(), 1, rnd_reg());
         step("R2", 1'b0);
      end

      // R6: a full group no longer fits
      for (int j = 0; j < W; j++) set_slot(j, 1, j, j + 1, 1, j + 10);
      step("R6", 1'b0);
      step("R6", 1'b0);

      // R7: slots without a destination take nothing from the ring
      set_slot(0, 1, 3, 4, 1, 11);
      set_slot(1, 1, 3, 4, 0, 12);
      set_slot(2, 1, 11, 2, 1, 12);
      set_slot(3, 1, 6, 7, 0, 13);
      step("R7", 1'b0);
      while (fl_cnt > 0) begin
         set_slot(0, 1, 1, 2, 1, 14);
         for (int j = 1; j < W; j++) set_slot(j, 1, j, j, 0, 0);
         step("R7", 1'b0);
      end
      set_slot(0, 1, 14, 2, 0, 0);
      step("R7", 1'b0);

      // R8: empty ring stalls a writer, a release during the stall is reused next
      set_slot(0, 1, 14, 3, 1, 15);
      for (int j = 1; j < W; j++) set_slot(j, 0, 0, 0, 0, 0);
      step("R6", 1'b1);
      step("R8", 1'b0);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         for (int j = 0; j < W; j++)
            set_slot(j, int'($urandom % 10 < 8), rnd_reg(), rnd_reg(),
                     int'($urandom % 10 < 7), rnd_reg());
         step("", bit'($urandom % 2));
      end

      finish_run();
   end

endmodule